// File: doc/BRIEF.md
# Field-Aware Display Fetch Address Generator

This block walks the visible window of a raster framebuffer and issues one 32-bit word address per request. A timing generator supplies strobes that mark the start of each field and each line, plus the parity of the current field. On every line start the block emits the addresses of one line of the window, one per accepted handshake. At the end of a line it moves a line pointer forward by a programmable step, measured from the last word fetched.

Progressive scan uses one base address and a step of one, so consecutive lines are contiguous. Interlaced scan uses two bases, one for the long (even) field and one for the short (odd) field. Software programs half the picture height and a step of one plus one line's worth of words, so each field reads alternate lines. The words per line come from the pixel width times the bit depth, rounded up to a multiple of 32 bits. The bases, the window size and the scan mode pass through shadow registers that load only while the retrace input is high. Panning updates therefore take effect at a field boundary and never in the middle of a picture.

Top module: `fetch_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `req_valid_o` is low.
- R2: `win_size_i` is decoded as line step in bits [29:20], line count minus one in bits [19:10] and words per line minus one in bits [9:0].
- R3: A line start strobe that is accepted raises `req_valid_o` in the next cycle. The block then issues words-minus-one plus one consecutive word addresses, starting at the current line pointer and wrapping modulo 2^ADDR_W.
- R4: After the last word of a line is accepted, the line pointer becomes that word's address plus the step. A step of 1 makes lines contiguous.
- R5: On a field start, the line pointer loads the short-field base when interlace is set and `field_odd_i` is 1. Otherwise it loads the long-field base, so progressive scan always uses the long base.
- R6: Once line count minus one plus one lines of a field have been issued, further line starts are ignored until the next field start. Line starts before the first field start after reset are also ignored.
- R7: While `req_ready_i` is low and valid is high, valid and the address hold. No address is skipped or repeated.
- R8: The bases, window size and interlace flag are captured only in cycles where `retrace_i` is high. Changes in other cycles have no effect.
- R9: A line start that arrives while a line is still being issued is ignored.
- R10: A field start abandons any partly issued line; valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retrace_i | input | 1 | Vertical retrace; shadow registers load while high |
| interlace_i | input | 1 | 1 selects interlaced scan |
| win_size_i | input | 30 | Packed step, line count minus one, words minus one |
| base_long_i | input | ADDR_W | Word address of the long (even) field start |
| base_short_i | input | ADDR_W | Word address of the short (odd) field start |
| field_start_i | input | 1 | Field start strobe |
| field_odd_i | input | 1 | Parity of the starting field (1 = short) |
| line_start_i | input | 1 | Line start strobe |
| req_ready_i | input | 1 | Consumer accepts the current address |
| req_valid_o | output | 1 | Address request valid |
| req_addr_o | output | ADDR_W | Word address of the request |

## Verification
The assertions assume that `retrace_i` is high only while no line is being issued, so the line width and step cannot change under an active line. They also assume the field strobes are single-cycle pulses. The stimulus follows these rules: it raises retrace only between drained lines and pulses each strobe for exactly one cycle. Ready is either held high or toggled in a fixed pattern that never depends on the address.

// File: rtl/fetch_addr_pkg.sv
package fetch_addr_pkg;
  localparam int unsigned FLD_W  = 10;
  localparam int unsigned SIZE_W = 3 * FLD_W;

  typedef logic [FLD_W-1:0] fld_t;

  // MSB first: step, lines-1, words-1
  typedef struct packed {
    fld_t step;
    fld_t lines_m1;
    fld_t words_m1;
  } win_cfg_t;
endpackage

// File: rtl/fad_shadow.sv
module fad_shadow
  import fetch_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retrace_i,
  input  logic              interlace_i,
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] base_long_i,
  input  logic [ADDR_W-1:0] base_short_i,
  output logic              interlace_o,
  output win_cfg_t          cfg_o,
  output logic [ADDR_W-1:0] base_long_o,
  output logic [ADDR_W-1:0] base_short_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interlace_o  <= 1'b0;
      cfg_o        <= '0;
      base_long_o  <= '0;
      base_short_o <= '0;
    end else if (retrace_i) begin
      interlace_o  <= interlace_i;
      cfg_o        <= cfg_i;
      base_long_o  <= base_long_i;
      base_short_o <= base_short_i;
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retrace_i |=> $stable(interlace_o) && $stable(cfg_o)
                   && $stable(base_long_o) && $stable(base_short_o));

endmodule

// File: rtl/fad_walker.sv
module fad_walker
  import fetch_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic              field_odd_i,
  input  logic              line_start_i,
  input  logic              interlace_i,
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] base_long_i,
  input  logic [ADDR_W-1:0] base_short_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              busy_q, live_q;
  logic [ADDR_W-1:0] line_base_q, addr_q;
  fld_t              word_q, line_q;
  logic              last_word, last_line;
  logic [ADDR_W-1:0] field_base, step_ext;

  always_comb begin
    last_word  = (word_q == cfg_i.words_m1);
    last_line  = (line_q == cfg_i.lines_m1);
    field_base = (interlace_i && field_odd_i) ? base_short_i : base_long_i;
    step_ext   = ADDR_W'(cfg_i.step);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      live_q      <= 1'b0;
      line_base_q <= '0;
      addr_q      <= '0;
      word_q      <= '0;
      line_q      <= '0;
    end else if (field_start_i) begin
      busy_q      <= 1'b0;
      live_q      <= 1'b1;
      line_q      <= '0;
      line_base_q <= field_base;
    end else if (!busy_q && line_start_i && live_q) begin
      busy_q <= 1'b1;
      addr_q <= line_base_q;
      word_q <= '0;
    end else if (busy_q && ready_i) begin
      if (last_word) begin
        busy_q      <= 1'b0;
        line_base_q <= addr_q + step_ext;
        if (last_line) live_q <= 1'b0;
        else           line_q <= line_q + 1'b1;
      end else begin
        addr_q <= addr_q + ADDR_W'(1);
        word_q <= word_q + 1'b1;
      end
    end
  end

  assign valid_o = busy_q;
  assign addr_o  = addr_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !field_start_i |=> valid_o && $stable(addr_o));

  // R3
  word_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_word && !field_start_i
      |=> valid_o && addr_o == $past(addr_o) + ADDR_W'(1));

  // R4
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_word && !field_start_i
      |=> !valid_o && line_base_q == $past(addr_o) + $past(step_ext));

  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> !valid_o);

  // R6
  field_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q && !field_start_i |=> !valid_o);

endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
  import fetch_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retrace_i,
  input  logic              interlace_i,
  input  logic [SIZE_W-1:0] win_size_i,
  input  logic [ADDR_W-1:0] base_long_i,
  input  logic [ADDR_W-1:0] base_short_i,
  input  logic              field_start_i,
  input  logic              field_odd_i,
  input  logic              line_start_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o
);

  logic              sh_interlace;
  win_cfg_t          sh_cfg;
  logic [ADDR_W-1:0] sh_long, sh_short;

  fad_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .retrace_i    (retrace_i),
    .interlace_i  (interlace_i),
    .cfg_i        (win_cfg_t'(win_size_i)),
    .base_long_i  (base_long_i),
    .base_short_i (base_short_i),
    .interlace_o  (sh_interlace),
    .cfg_o        (sh_cfg),
    .base_long_o  (sh_long),
    .base_short_o (sh_short)
  );

  fad_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .field_start_i (field_start_i),
    .field_odd_i   (field_odd_i),
    .line_start_i  (line_start_i),
    .interlace_i   (sh_interlace),
    .cfg_i         (sh_cfg),
    .base_long_i   (sh_long),
    .base_short_i  (sh_short),
    .ready_i       (req_ready_i),
    .valid_o       (req_valid_o),
    .addr_o        (req_addr_o)
  );

endmodule

// File: tb/fetch_addr_gen_tb.sv
module fetch_addr_gen_tb;
  localparam int AW = 24;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0, retrace = 1'b0, il = 1'b0;
  logic          fs = 1'b0, fodd = 1'b0, ls = 1'b0, ready = 1'b1;
  logic [29:0]   size = '0;
  logic [AW-1:0] bl = '0, bs = '0;
  logic          valid;
  logic [AW-1:0] addr;

  fetch_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .retrace_i(retrace), .interlace_i(il),
    .win_size_i(size), .base_long_i(bl), .base_short_i(bs),
    .field_start_i(fs), .field_odd_i(fodd), .line_start_i(ls),
    .req_ready_i(ready), .req_valid_o(valid), .req_addr_o(addr)
  );

  int    checks = 0, fails = 0, cyc = 0, pat = 0;
  string tag = "R1";
  bit    stall_en = 1'b0;

  // reference model
  longint m_long = 0, m_short = 0, m_size = 0, m_base = 0;
  bit     m_il = 0, m_live = 0;
  int     m_done = 0;
  longint q[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // R2: step [29:20], lines-1 [19:10], words-1 [9:0]
  function automatic logic [29:0] pack(int step, int lines_m1, int words_m1);
    return {step[9:0], lines_m1[9:0], words_m1[9:0]};
  endfunction

  task automatic tick();
    if (!rst_ni) chk(valid == 1'b0, "R1", "valid in reset", valid, 0);
    else if (q.size() == 0) chk(valid == 1'b0, tag, "valid idle", valid, 0);
    else begin
      chk(valid == 1'b1, tag, "valid busy", valid, 1);
      if (valid) chk(addr == q[0][AW-1:0], tag, "addr", addr, q[0]);
    end
    if (!rst_ni) begin
      q.delete(); m_live = 0; m_long = 0; m_short = 0; m_size = 0; m_il = 0; m_base = 0;
    end else begin
      if (fs) begin
        q.delete();
        m_base = (m_il && fodd) ? m_short : m_long;
        m_live = 1; m_done = 0;
      end else if (q.size() == 0 && ls && m_live) begin
        longint w = (m_size & 'h3ff) + 1;
        longint st = (m_size >> 20) & 'h3ff;
        for (longint i = 0; i < w; i++) q.push_back((m_base + i) & AMASK);
        m_base = (m_base + w - 1 + st) & AMASK;
        m_done++;
        if (m_done == ((m_size >> 10) & 'h3ff) + 1) m_live = 0;
      end else if (q.size() > 0 && ready) begin
        void'(q.pop_front());
      end
      if (retrace) begin
        m_long = bl; m_short = bs; m_size = size; m_il = il;
      end
    end
    @(posedge clk); #1;
    if (stall_en) begin pat++; ready = (pat % 3) != 2; end
  endtask

  task automatic program_cfg(longint lng, longint sht, logic [29:0] sz, bit inter);
    bl = lng[AW-1:0]; bs = sht[AW-1:0]; size = sz; il = inter; retrace = 1'b1;
    tick();
    retrace = 1'b0;
  endtask

  task automatic field(bit odd);
    fs = 1'b1; fodd = odd; tick(); fs = 1'b0;
  endtask

  task automatic line_run();
    ls = 1'b1; tick(); ls = 1'b0;
    for (int i = 0; i < 5000 && q.size() > 0; i++) tick();
    tick();
  endtask

  initial begin
    // R1
    tag = "R1";
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (2) tick();
    // R6: line start before any field start is ignored
    tag = "R6";
    ls = 1'b1; tick(); ls = 1'b0;
    repeat (3) tick();

    // R2 R3 R4: progressive, 4 words, 3 lines, step 1
    tag = "R2";
    program_cfg('h1000, 'h1004, pack(1, 2, 3), 1'b0);
    field(1'b0);
    tag = "R3"; line_run();
    tag = "R4"; line_run(); line_run();
    // R6: fourth line ignored
    tag = "R6"; line_run();

    // R5: interlaced, step = 1 + words
    tag = "R5";
    program_cfg('h1000, 'h1004, pack(5, 2, 3), 1'b1);
    field(1'b1); repeat (3) line_run();
    field(1'b0); repeat (3) line_run();
    // R5: progressive with odd parity still uses long base
    program_cfg('h3000, 'h5000, pack(1, 1, 2), 1'b0);
    field(1'b1); line_run(); line_run();

    // R3: address wrap and long line
    tag = "R3";
    program_cfg('hFFFFFE, 'h0, pack(1, 0, 20), 1'b0);
    field(1'b0); line_run();

    // R7: stalls
    tag = "R7";
    program_cfg('h2000, 'h2010, pack(3, 2, 6), 1'b0);
    stall_en = 1'b1;
    field(1'b0); repeat (3) line_run();
    stall_en = 1'b0; ready = 1'b1;

    // R8: changes outside retrace have no effect
    tag = "R8";
    bl = 'h7000; size = pack(1, 0, 1); il = 1'b1;
    repeat (2) tick();
    field(1'b0); line_run(); line_run();

    // R9: line start during an active line
    tag = "R9";
    field(1'b0);
    ls = 1'b1; tick(); ls = 1'b0;
    tick();
    ls = 1'b1; tick(); ls = 1'b0;
    for (int i = 0; i < 100 && q.size() > 0; i++) tick();
    tick(); tick();

    // R10: field start mid-line
    tag = "R10";
    field(1'b0);
    ls = 1'b1; tick(); ls = 1'b0;
    tick(); tick();
    field(1'b0);
    tick();
    line_run();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule